// File: doc/BRIEF.md
# Programmable sync waveform sequencer

This block produces the data-enable signal, an 8-bit level and a mux-select bit for a digital pixel output, advancing one pixel per clock. The timing comes from a small program that software writes into a 64-word instruction store. Each instruction either sets the outputs, keeps them for a counted number of pixels, loops back over a group of instructions, jumps, or halts. With these instructions one program can describe both the horizontal and the vertical blanking and active regions.

Software loads the store through a word-addressed register port and then sets the run bit in the control register. An external timing generator supplies a line-start strobe and a frame-start strobe. A line-replay loop waits for the line strobe before each extra pass. A halted program waits for the frame strobe and then restarts from address 0. In frame-locked mode the frame strobe also restarts a running program, and after enable the program waits for that strobe before its first instruction.

The register port has no handshake. A write takes effect at the clock edge where `cfg_we` is high. A read returns data combinationally for the address on `cfg_addr`.

Top module: `sync_wave_seq`

## Requirements
- R1: An instruction is 14 bits with the opcode in bits 13:10 (set=0, repeat-mark set=1, replay-mark set=2, skip=3, stop=4, repeat=5, replay=6, jump=7, hold=8). Set, repeat-mark set and replay-mark set each take one clock. They drive the level from bits 7:0, mux-select from bit 8 and data-enable from bit 9, and the new values appear on the outputs after that clock edge.
- R2: Skip with count N (bits 9:0, 1..1023) takes N+1 clocks, during which the outputs do not change. A set followed by skip N therefore holds its values for N+2 pixels.
- R3: A skip with count 0, or an opcode from 9 to 15, sets a sticky error and then behaves as stop. The error is visible on `seq_err` and at control register bit 8. Writing the control register with bit 8 at 1 clears it.
- R4: The repeat-mark set records its own address as the repeat group start. Repeat N (bits 9:0) runs the group N more times. Repeat 0 falls through.
- R5: The replay-mark set records the replay group start. Replay N runs that group N more times, and each extra pass starts only at a line-start strobe. Replay 0 falls through. A line strobe at any other time has no effect.
- R6: Stop keeps the outputs unchanged until a frame-start strobe. After the strobe, execution restarts at address 0 and both loop counters are cleared.
- R7: Hold drives the outputs from bits 9:0 as set does, then behaves as stop.
- R8: Jump continues execution at the address held in bits 5:0. Bit 6 of its argument is always set by software.
- R9: Instruction word i is at byte offset 0x100+4*i for i = 0..63. It reads back as the 14 bits written, zero-extended. Words never written read as zero.
- R10: The control register is at offset 0. Bit 0 is run enable and bit 2 selects frame-locked mode; both read back as written.
- R11: In the clock after run enable is written to 0, data-enable, mux-select and level are all 0. A later enable restarts the program at address 0.
- R12: In frame-locked mode the first instruction after enable waits for a frame-start strobe, and a frame-start strobe while running restarts execution at address 0.
- R13: After reset all outputs are 0, the control register is 0 and the instruction store reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | pixel clock |
| rst_n | input | 1 | active-low synchronous reset |
| cfg_we | input | 1 | register write strobe |
| cfg_addr | input | 10 | register byte address |
| cfg_wdata | input | 32 | register write data |
| cfg_rdata | output | 32 | register read data for `cfg_addr` |
| line_start | input | 1 | line-start strobe from the timing generator |
| frame_start | input | 1 | frame-start strobe from the timing generator |
| de_out | output | 1 | data-enable |
| mux_out | output | 1 | mux-select bit |
| level_out | output | 8 | level output |
| seq_err | output | 1 | sticky program error |

## Verification
The bench measures the widths of data-enable pulses for random skip counts and for the largest count. An off-by-one in the skip counter shows up there as a pulse one pixel too short or too long. It counts pulses for repeat and replay loops, including a zero count. A loop that runs once too often or too rarely, or a replay that does not wait for the line strobe, changes that count. It also checks that a pulse appears after a frame strobe when the program is halted, that the first instruction waits in frame-locked mode, that a frame strobe mid-pulse lengthens the pulse through a restart, and that jump skips the instruction it passes over. Illegal opcodes and a zero skip must raise the sticky error. Disabling must clear the outputs one clock after the write and not resume from the old address.

// File: rtl/sws_pkg.sv
package sws_pkg;
  localparam int INSTR_W = 14;
  localparam int OP_LSB  = 10;
  localparam int LVL_W   = 8;
  localparam int CNT_W   = 10;

  localparam logic [3:0] OP_SET    = 4'd0;
  localparam logic [3:0] OP_RPTSET = 4'd1;
  localparam logic [3:0] OP_RPLSET = 4'd2;
  localparam logic [3:0] OP_SKIP   = 4'd3;
  localparam logic [3:0] OP_STOP   = 4'd4;
  localparam logic [3:0] OP_REPEAT = 4'd5;
  localparam logic [3:0] OP_REPLAY = 4'd6;
  localparam logic [3:0] OP_JUMP   = 4'd7;
  localparam logic [3:0] OP_HOLD   = 4'd8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RUN,
    ST_SKIP,
    ST_WLINE,
    ST_WFRAME
  } seq_state_e;
endpackage

// File: rtl/sws_regs.sv
module sws_regs
  import sws_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 32,
  parameter int DEPTH     = 64,
  parameter int IMEM_BASE = 'h100,
  localparam int PTR_W    = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [ADDR_W-1:0]  cfg_addr,
  input  logic [DATA_W-1:0]  cfg_wdata,
  output logic [DATA_W-1:0]  cfg_rdata,
  input  logic               err_set,
  output logic               ctrl_en,
  output logic               ctrl_fsync,
  output logic               err_q,
  input  logic [PTR_W-1:0]   fetch_addr,
  output logic [INSTR_W-1:0] fetch_word
);
  localparam logic [ADDR_W-1:0] BASE    = ADDR_W'(IMEM_BASE);
  localparam logic [ADDR_W:0]   MEM_END = (ADDR_W+1)'(IMEM_BASE + 4*DEPTH);

  logic [INSTR_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0]  offs;
  logic [PTR_W-1:0]   idx;
  logic               hit_mem, hit_ctrl;
  logic               unused_bits;

  assign offs     = cfg_addr - BASE;
  assign idx      = offs[PTR_W+1:2];
  assign hit_mem  = ({1'b0, cfg_addr} >= {1'b0, BASE}) && ({1'b0, cfg_addr} < MEM_END);
  assign hit_ctrl = (cfg_addr == '0);
  assign unused_bits = ^{offs[1:0], offs[ADDR_W-1:PTR_W+2], cfg_wdata[DATA_W-1:INSTR_W]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (cfg_we && hit_mem) begin
      mem[idx] <= cfg_wdata[INSTR_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_en    <= 1'b0;
      ctrl_fsync <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      if (cfg_we && hit_ctrl) begin
        ctrl_en    <= cfg_wdata[0];
        ctrl_fsync <= cfg_wdata[2];
      end
      if (err_set) err_q <= 1'b1;
      else if (cfg_we && hit_ctrl && cfg_wdata[8]) err_q <= 1'b0;
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (hit_ctrl) begin
      cfg_rdata[0] = ctrl_en;
      cfg_rdata[2] = ctrl_fsync;
      cfg_rdata[8] = err_q;
    end else if (hit_mem) begin
      cfg_rdata[INSTR_W-1:0] = mem[idx];
    end
  end

  assign fetch_word = mem[fetch_addr];
endmodule

// File: rtl/sws_core.sv
module sws_core
  import sws_pkg::*;
#(
  parameter int DEPTH  = 64,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               fsync,
  input  logic               line_start,
  input  logic               frame_start,
  output logic [PTR_W-1:0]   fetch_addr,
  input  logic [INSTR_W-1:0] fetch_word,
  output logic               de_q,
  output logic               mux_q,
  output logic [LVL_W-1:0]   lvl_q,
  output logic               err_set
);
  seq_state_e       st;
  logic [PTR_W-1:0] pc, rpt_start, rpl_start, pc_inc;
  logic [CNT_W-1:0] skip_cnt, rpt_cnt, rpl_cnt;
  logic             rpt_busy, rpl_busy;
  logic [3:0]       op;
  logic [CNT_W-1:0] arg;
  logic             restart, bad_op;

  assign fetch_addr = pc;
  assign pc_inc     = pc + 1'b1;
  assign op         = fetch_word[INSTR_W-1:OP_LSB];
  assign arg        = fetch_word[CNT_W-1:0];
  assign restart    = frame_start && (st == ST_WFRAME || (fsync && st != ST_IDLE));
  assign bad_op     = (op > OP_HOLD) || (op == OP_SKIP && arg == '0);
  assign err_set    = en && !restart && st == ST_RUN && bad_op;

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      st <= ST_IDLE; pc <= '0;
      rpt_busy <= 1'b0; rpl_busy <= 1'b0;
      rpt_start <= '0; rpl_start <= '0;
      rpt_cnt <= '0; rpl_cnt <= '0; skip_cnt <= '0;
      de_q <= 1'b0; mux_q <= 1'b0; lvl_q <= '0;
    end else if (restart) begin
      st <= ST_RUN; pc <= '0;
      rpt_busy <= 1'b0; rpl_busy <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          pc <= '0;
          st <= fsync ? ST_WFRAME : ST_RUN;
        end
        ST_RUN: begin
          case (op)
            OP_SET, OP_RPTSET, OP_RPLSET, OP_HOLD: begin
              lvl_q <= fetch_word[LVL_W-1:0];
              mux_q <= fetch_word[8];
              de_q  <= fetch_word[9];
              pc    <= pc_inc;
              if (op == OP_RPTSET) rpt_start <= pc;
              if (op == OP_RPLSET) rpl_start <= pc;
              if (op == OP_HOLD) begin pc <= pc; st <= ST_WFRAME; end
            end
            OP_SKIP: begin
              if (arg == '0) st <= ST_WFRAME;
              else begin skip_cnt <= arg; st <= ST_SKIP; end
            end
            OP_STOP: st <= ST_WFRAME;
            OP_REPEAT: begin
              if (!rpt_busy) begin
                if (arg == '0) pc <= pc_inc;
                else begin rpt_cnt <= arg - 1'b1; rpt_busy <= 1'b1; pc <= rpt_start; end
              end else if (rpt_cnt == '0) begin
                rpt_busy <= 1'b0; pc <= pc_inc;
              end else begin
                rpt_cnt <= rpt_cnt - 1'b1; pc <= rpt_start;
              end
            end
            OP_REPLAY: begin
              if (!rpl_busy) begin
                if (arg == '0) pc <= pc_inc;
                else begin rpl_cnt <= arg - 1'b1; rpl_busy <= 1'b1; st <= ST_WLINE; end
              end else if (rpl_cnt == '0) begin
                rpl_busy <= 1'b0; pc <= pc_inc;
              end else begin
                rpl_cnt <= rpl_cnt - 1'b1; st <= ST_WLINE;
              end
            end
            OP_JUMP: pc <= fetch_word[PTR_W-1:0];
            default: st <= ST_WFRAME;
          endcase
        end
        ST_SKIP: begin
          if (skip_cnt == CNT_W'(1)) begin pc <= pc_inc; st <= ST_RUN; end
          else skip_cnt <= skip_cnt - 1'b1;
        end
        ST_WLINE: begin
          if (line_start) begin pc <= rpl_start; st <= ST_RUN; end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sync_wave_seq.sv
module sync_wave_seq
  import sws_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 32,
  parameter int DEPTH     = 64,
  parameter int IMEM_BASE = 'h100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic              line_start,
  input  logic              frame_start,
  output logic              de_out,
  output logic              mux_out,
  output logic [LVL_W-1:0]  level_out,
  output logic              seq_err
);
  localparam int PTR_W = $clog2(DEPTH);

  logic               ctrl_en, ctrl_fsync, err_set, core_de, core_mux;
  logic [LVL_W-1:0]   core_lvl;
  logic [PTR_W-1:0]   fetch_addr;
  logic [INSTR_W-1:0] fetch_word;

  sws_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .IMEM_BASE(IMEM_BASE)) u_regs (
    .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata, .cfg_rdata,
    .err_set, .ctrl_en, .ctrl_fsync, .err_q(seq_err),
    .fetch_addr, .fetch_word
  );

  sws_core #(.DEPTH(DEPTH)) u_core (
    .clk, .rst_n, .en(ctrl_en), .fsync(ctrl_fsync), .line_start, .frame_start,
    .fetch_addr, .fetch_word, .de_q(core_de), .mux_q(core_mux), .lvl_q(core_lvl),
    .err_set
  );

  assign de_out    = core_de & ctrl_en;
  assign mux_out   = core_mux & ctrl_en;
  assign level_out = ctrl_en ? core_lvl : '0;
endmodule

// File: rtl/sws_chk.sv
module sws_chk #(
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 32,
  parameter int DEPTH     = 64,
  parameter int IMEM_BASE = 'h100
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [ADDR_W-1:0] cfg_addr,
  input logic [DATA_W-1:0] cfg_wdata,
  input logic [DATA_W-1:0] cfg_rdata,
  input logic              de_out,
  input logic              mux_out,
  input logic [7:0]        level_out,
  input logic              seq_err
);
  localparam logic [DATA_W-1:0] WMASK = DATA_W'(14'h3fff);
  logic ctrl_wr, mem_wr;
  assign ctrl_wr = cfg_we && cfg_addr == '0;
  assign mem_wr  = cfg_we && (32'(cfg_addr) >= IMEM_BASE) && (32'(cfg_addr) < IMEM_BASE + 4*DEPTH);

  // R11
  disable_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr && !cfg_wdata[0] |=> !de_out && !mux_out && level_out == 8'd0);

  // R3
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err && !(ctrl_wr && cfg_wdata[8]) |=> seq_err);

  // R9
  imem_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> (cfg_addr != $past(cfg_addr)) || (cfg_rdata == ($past(cfg_wdata) & WMASK)));

  // R10
  ctrl_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (cfg_addr != '0) ||
      (cfg_rdata[0] == $past(cfg_wdata[0]) && cfg_rdata[2] == $past(cfg_wdata[2])));
endmodule

bind sync_wave_seq sws_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .IMEM_BASE(IMEM_BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
  .cfg_rdata(cfg_rdata), .de_out(de_out), .mux_out(mux_out), .level_out(level_out),
  .seq_err(seq_err)
);

// File: tb/test_sync_wave_seq.sv
module test_sync_wave_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [9:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        line_start = 1'b0, frame_start = 1'b0;
  logic        de_out, mux_out, seq_err;
  logic [7:0]  level_out;

  int total = 0, bad = 0;
  bit done = 0;
  int rises = 0, cur_w = 0, last_w = 0;
  bit de_prev = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_wave_seq i_sync_wave_seq (
    .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata, .cfg_rdata,
    .line_start, .frame_start, .de_out, .mux_out, .level_out, .seq_err
  );

  always @(negedge clk) begin
    if (de_out) begin
      if (!de_prev) begin rises++; cur_w = 1; end
      else cur_w++;
    end else if (de_prev) last_w = cur_w;
    de_prev = de_out;
  end

  function automatic logic [13:0] i_out(logic [3:0] op, bit de, bit mx, logic [7:0] lv);
    return {op, de, mx, lv};
  endfunction
  function automatic logic [13:0] i_cnt(logic [3:0] op, int n);
    return {op, 10'(n)};
  endfunction
  function automatic int exp_skip_width(int n);
    return n + 2;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = 10'(a); cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask
  task automatic rd(int a, output logic [31:0] d);
    @(negedge clk); cfg_addr = 10'(a); #1 d = cfg_rdata;
  endtask
  task automatic wi(int i, logic [13:0] w);
    wr('h100 + 4*i, {18'd0, w});
  endtask
  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic pulse_line;
    @(negedge clk); line_start = 1'b1; @(negedge clk); line_start = 1'b0;
  endtask
  task automatic pulse_frame;
    @(negedge clk); frame_start = 1'b1; @(negedge clk); frame_start = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [13:0] exp_mem [64];
    int base, n;
    void'($urandom(32'd4242));
    for (int i = 0; i < 64; i++) exp_mem[i] = '0;
    cyc(3); rst_n = 1'b1; cyc(1);

    // R13 reset state
    chk(!de_out && level_out == 0 && !mux_out && !seq_err, "R13 outputs", int'(level_out), 0);
    rd(0, d); chk(d == 0, "R13 ctrl", int'(d), 0);

    // R9 random readback, even slots only; odd slots stay zero
    for (int k = 0; k < 20; k++) begin
      int s = 2 * int'($urandom % 32);
      logic [31:0] v = $urandom;
      wr('h100 + 4*s, v); exp_mem[s] = v[13:0];
    end
    for (int s = 0; s < 64; s += 2) begin
      rd('h100 + 4*s, d); chk(d == {18'd0, exp_mem[s]}, "R9 readback", int'(d), int'(exp_mem[s]));
    end
    n = 2 * int'($urandom % 32) + 1;
    rd('h100 + 4*n, d); chk(d == 0, "R9 unwritten zero", int'(d), 0);

    // R10 control readback
    wr(0, 32'h4); rd(0, d); chk(d == 32'h4, "R10 ctrl", int'(d), 4);
    wr(0, 32'h0);

    // R1 R2 set + skip widths, random counts and the largest one
    for (int k = 0; k < 5; k++) begin
      n = (k == 4) ? 1023 : 1 + int'($urandom % 20);
      wi(0, i_out(4'd0, 1, 1, 8'h55)); wi(1, i_cnt(4'd3, n));
      wi(2, i_out(4'd0, 0, 0, 8'h10)); wi(3, i_cnt(4'd4, 0));
      base = rises;
      wr(0, 32'h1); cyc(4);
      chk(de_out && mux_out && level_out == 8'h55, "R1 set fields", int'(level_out), 'h55);
      cyc(n + 10);
      chk(rises == base + 1, "R2 one pulse", rises - base, 1);
      chk(last_w == exp_skip_width(n), "R2 skip width", last_w, exp_skip_width(n));
      chk(level_out == 8'h10 && !mux_out, "R1 second set", int'(level_out), 'h10);
      wr(0, 32'h0);
    end

    // R4 repeat loops: zero, random, largest
    for (int k = 0; k < 3; k++) begin
      n = (k == 0) ? 0 : (k == 1) ? 1 + int'($urandom % 6) : 1023;
      wi(0, i_out(4'd1, 1, 0, 8'h40)); wi(1, i_out(4'd0, 0, 0, 8'h00));
      wi(2, i_cnt(4'd5, n)); wi(3, i_cnt(4'd4, 0));
      base = rises;
      wr(0, 32'h1); cyc(3 * n + 20);
      chk(rises == base + n + 1, "R4 repeat passes", rises - base, n + 1);
      wr(0, 32'h0);
    end

    // R5 replay waits for line strobes; R6 frame restart
    wi(0, i_out(4'd2, 1, 0, 8'h80)); wi(1, i_cnt(4'd3, 2));
    wi(2, i_out(4'd0, 0, 0, 8'h10)); wi(3, i_cnt(4'd6, 3)); wi(4, i_cnt(4'd4, 0));
    base = rises;
    wr(0, 32'h1); cyc(30);
    chk(rises == base + 1, "R5 waits for line", rises - base, 1);
    chk(last_w == 4, "R5 pass width", last_w, 4);
    for (int k = 0; k < 5; k++) begin pulse_line(); cyc(20); end
    chk(rises == base + 4, "R5 replay passes", rises - base, 4);
    pulse_frame(); cyc(20);
    chk(rises == base + 5, "R6 frame restart", rises - base, 5);
    chk(level_out == 8'h10, "R6 stop holds", int'(level_out), 'h10);
    wr(0, 32'h0);

    // R5 replay 0 falls through without waiting
    wi(3, i_cnt(4'd6, 0)); wi(4, i_out(4'd0, 0, 0, 8'h2A)); wi(5, i_cnt(4'd4, 0));
    wr(0, 32'h1); cyc(20);
    chk(level_out == 8'h2A, "R5 replay zero", int'(level_out), 'h2A);
    wr(0, 32'h0);

    // R8 jump skips the instruction it passes
    wi(0, i_out(4'd0, 0, 0, 8'h01)); wi(1, i_cnt(4'd7, 'h43));
    wi(2, i_out(4'd0, 1, 0, 8'hEE)); wi(3, i_out(4'd0, 0, 0, 8'h33)); wi(4, i_cnt(4'd4, 0));
    base = rises;
    wr(0, 32'h1); cyc(20);
    chk(rises == base && level_out == 8'h33, "R8 jump", int'(level_out), 'h33);
    wr(0, 32'h0);

    // R7 hold sets then halts
    wi(0, i_out(4'd8, 1, 0, 8'h07)); wi(1, i_out(4'd0, 0, 0, 8'h00));
    wr(0, 32'h1); cyc(30);
    chk(de_out && level_out == 8'h07, "R7 hold", int'(level_out), 7);
    wr(0, 32'h0);

    // R3 unknown opcode and zero skip
    wi(0, {4'd12, 10'h2FF});
    wr(0, 32'h1); cyc(10);
    chk(seq_err && !de_out, "R3 bad opcode", int'(seq_err), 1);
    rd(0, d); chk(d[8] == 1'b1, "R3 ctrl bit8", int'(d[8]), 1);
    wr(0, 32'h101); cyc(5);
    chk(!seq_err, "R3 clear", int'(seq_err), 0);
    wr(0, 32'h0);
    wi(0, i_out(4'd0, 0, 0, 8'h05)); wi(1, i_cnt(4'd3, 0)); wi(2, i_out(4'd0, 1, 0, 8'h06));
    wr(0, 32'h1); cyc(10);
    chk(seq_err && level_out == 8'h05 && !de_out, "R3 skip zero", int'(level_out), 5);
    wr(0, 32'h100);

    // R11 disable clears outputs next clock, re-enable starts at 0
    wi(0, i_out(4'd0, 1, 1, 8'h99)); wi(1, i_cnt(4'd3, 200)); wi(2, i_cnt(4'd4, 0));
    base = rises;
    wr(0, 32'h1); cyc(20);
    chk(de_out && level_out == 8'h99, "R11 running", int'(level_out), 'h99);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = '0; cfg_wdata = 32'h0;
    @(negedge clk); cfg_we = 1'b0;
    chk(!de_out && !mux_out && level_out == 0, "R11 quiet", int'(level_out), 0);
    wr(0, 32'h1); cyc(10);
    chk(rises == base + 2 && de_out, "R11 restart", rises - base, 2);
    wr(0, 32'h0);

    // R12 frame-locked mode
    wi(0, i_out(4'd0, 1, 0, 8'h21)); wi(1, i_cnt(4'd3, 4));
    wi(2, i_out(4'd0, 0, 0, 8'h00)); wi(3, i_cnt(4'd4, 0));
    base = rises;
    wr(0, 32'h5); cyc(30);
    chk(rises == base, "R12 waits for frame", rises - base, 0);
    pulse_frame(); cyc(30);
    chk(rises == base + 1 && last_w == exp_skip_width(4), "R12 first pass", last_w, 6);
    wr(0, 32'h0);
    wi(1, i_cnt(4'd3, 100));
    wr(0, 32'h5); cyc(3); pulse_frame(); cyc(20); pulse_frame(); cyc(150);
    chk(last_w > exp_skip_width(100), "R12 restart lengthens", last_w, exp_skip_width(100) + 1);
    wr(0, 32'h0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule